// File: doc/BRIEF.md
# Link Event Counter Bank

This block counts traffic events on an inter-socket link. Eight 64-bit counters each watch one of four packet-sent strobes from the link (request, snoop, data and interrupt-controller packets). Each counter has its own configuration word that picks the event by code and sets how the strobe is counted: once per edge or once per cycle, with either polarity. One shared control word enables counting, starts it and clears every counter.

Software reaches the bank through a 32-bit register port. A counter is read indirectly. Software writes a selector, which takes a snapshot of the chosen 64-bit counter. It then reads the snapshot as a low word and a high word. Both halves come from the same instant, so they always match each other, even while counting goes on.

Top module: `lnk_pmu_bank`

## Requirements
- R1: After reset every counter is zero, and the shared control (0x108), all configuration words, the selector (0x12C) and both data words (0x130, 0x134) read back zero.
- R2: The shared control word at 0x108 has enable in bit 0 and start in bit 1. A counter advances only on a clock edge where both bits are set. With either bit clear, or after writing 0, every counter holds its value.
- R3: Writing bit 4 of 0x108 clears all counters on the following clock edge. Bit 4 reads back as 1 for that one cycle and as 0 from then on.
- R4: Counter n has a configuration word at 0x10C + 4*n (n = 0..7). Bits [9:0] hold the event code, bit 10 the polarity and bit 11 the mode. Only bits [11:0] are stored and read back. Each counter follows its own word independently of the others.
- R5: Event codes map to strobe input bits as follows: 0x3D to evt_in[0] (request), 0x65 to evt_in[1] (snoop), 0x105 to evt_in[2] (data) and 0x12D to evt_in[3] (interrupt controller). A counter with any other code never advances, whatever its mode and polarity.
- R6: When bit 11 is 1, the counter adds one on each rising transition of its strobe if bit 10 is 1, and on each falling transition if bit 10 is 0. Transitions are measured between consecutive clock edges, starting from a low strobe at reset.
- R7: When bit 11 is 0, the counter adds one on every clock edge where its strobe is high if bit 10 is 1, and on every edge where its strobe is low if bit 10 is 0.
- R8: Writing the value 8 + n to the selector at 0x12C captures counter n as it stands at that edge. Writing any other value captures zero. The selector reads back the low 8 bits that were written.
- R9: 0x130 returns bits [31:0] of the captured value and 0x134 returns bits [63:32]. The captured value does not change until the next selector write, even while the counters keep running.
- R10: Read data appears on rdata one cycle after rd_en and holds until the next read. A read of any address outside the listed registers returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Register byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| evt_in | input | 4 | Packet-sent strobes: bit 0 request, 1 snoop, 2 data, 3 interrupt controller |

## Verification
The following timings apply, counting from the edge that samples the stimulus:
- A strobe level counts on that same edge, but only if the control word was already set before that edge. A control write therefore affects counting from the next edge onward.
- A reset request clears the counters one edge after its write.
- A selector write captures on its own edge.
- Read data is valid after the edge that samples rd_en.

The bench drives every input on the falling edge and samples rdata on the falling edge after each read. It counts the edges in each scenario by hand, including the edge taken by a control write. Counters are frozen before they are selected, so each captured value is exact.

// File: rtl/lnk_pmu_pkg.sv
package lnk_pmu_pkg;

    localparam int EVT_N    = 4;
    localparam int CODE_W   = 10;
    localparam int SEL_W    = 8;
    localparam int SEL_BASE = 8;

    localparam logic [11:0] OFS_CTL  = 12'h108;
    localparam logic [11:0] OFS_CFG0 = 12'h10C;
    localparam logic [11:0] OFS_SEL  = 12'h12C;
    localparam logic [11:0] OFS_LO   = 12'h130;
    localparam logic [11:0] OFS_HI   = 12'h134;

    localparam logic [CODE_W-1:0] CODE_REQ  = 10'h03D;
    localparam logic [CODE_W-1:0] CODE_SNP  = 10'h065;
    localparam logic [CODE_W-1:0] CODE_DAT  = 10'h105;
    localparam logic [CODE_W-1:0] CODE_IRQ  = 10'h12D;

    // Per-counter configuration: mode bit 11, polarity bit 10, code [9:0]
    typedef struct packed {
        logic              edge_mode;
        logic              pol_high;
        logic [CODE_W-1:0] code;
    } cnt_cfg_t;

    typedef struct packed {
        logic clr;
        logic start;
        logic en;
    } glb_ctl_t;

    function automatic logic [EVT_N-1:0] code_to_onehot(input logic [CODE_W-1:0] code);
        logic [EVT_N-1:0] oh;
        case (code)
            CODE_REQ: oh = 4'b0001;
            CODE_SNP: oh = 4'b0010;
            CODE_DAT: oh = 4'b0100;
            CODE_IRQ: oh = 4'b1000;
            default:  oh = '0;
        endcase
        return oh;
    endfunction

endpackage

// File: rtl/lnk_pmu_trig.sv
module lnk_pmu_trig
    import lnk_pmu_pkg::*;
#(
    parameter int NUM_CNT = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [EVT_N-1:0]          evt_in,
    input  cnt_cfg_t [NUM_CNT-1:0]    cfg,
    output logic [NUM_CNT-1:0]        hit
);

    typedef struct packed {
        logic [EVT_N-1:0] prev;
    } trig_st_t;

    trig_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = evt_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // One qualifier per counter: code decode, then edge or level test
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_qual
        logic [EVT_N-1:0] sel_oh;
        logic             cur, prv, valid, fire;

        always_comb begin
            sel_oh = code_to_onehot(cfg[g].code);
            valid  = |sel_oh;
            cur    = |(sel_oh & evt_in);
            prv    = |(sel_oh & st_q.prev);
            if (cfg[g].edge_mode)
                fire = cfg[g].pol_high ? (cur & ~prv) : (~cur & prv);
            else
                fire = cfg[g].pol_high ? cur : ~cur;
        end

        assign hit[g] = valid & fire;
    end

endmodule

// File: rtl/lnk_pmu_ctr.sv
module lnk_pmu_ctr #(
    parameter int NUM_CNT = 8,
    parameter int CNT_W   = 64
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             run,
    input  logic                             clr,
    input  logic [NUM_CNT-1:0]               hit,
    output logic [NUM_CNT-1:0][CNT_W-1:0]    cnt
);

    typedef struct packed {
        logic [NUM_CNT-1:0][CNT_W-1:0] val;
    } ctr_st_t;

    ctr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_CNT; i++) begin
            if (clr)
                st_d.val[i] = '0;
            else if (run && hit[i])
                st_d.val[i] = st_q.val[i] + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.val;

endmodule

// File: rtl/lnk_pmu_regs.sv
module lnk_pmu_regs
    import lnk_pmu_pkg::*;
#(
    parameter int NUM_CNT = 8,
    parameter int CNT_W   = 64,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic                             rd_en,
    input  logic [ADDR_W-1:0]                addr,
    input  logic [DATA_W-1:0]                wdata,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]    cnt,
    output logic [DATA_W-1:0]                rdata,
    output glb_ctl_t                         ctl,
    output cnt_cfg_t [NUM_CNT-1:0]           cfg,
    output logic [CNT_W-1:0]                 snap
);

    localparam int CFG_W = $bits(cnt_cfg_t);

    typedef struct packed {
        glb_ctl_t                ctl;
        cnt_cfg_t [NUM_CNT-1:0]  cfg;
        logic [SEL_W-1:0]        sel;
        logic [CNT_W-1:0]        snap;
        logic [DATA_W-1:0]       rdata;
    } reg_st_t;

    reg_st_t st_d, st_q;
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        st_d = st_q;

        // reset request lasts one cycle unless rewritten
        st_d.ctl.clr = 1'b0;

        if (wr_en) begin
            if (addr == ADDR_W'(OFS_CTL)) begin
                st_d.ctl.en    = wdata[0];
                st_d.ctl.start = wdata[1];
                st_d.ctl.clr   = wdata[4];
            end
            for (int i = 0; i < NUM_CNT; i++) begin
                if (addr == ADDR_W'(int'(OFS_CFG0) + 4 * i))
                    st_d.cfg[i] = cnt_cfg_t'(wdata[CFG_W-1:0]);
            end
            if (addr == ADDR_W'(OFS_SEL)) begin
                st_d.sel  = wdata[SEL_W-1:0];
                st_d.snap = '0;
                for (int i = 0; i < NUM_CNT; i++) begin
                    if (wdata == DATA_W'(SEL_BASE + i))
                        st_d.snap = cnt[i];
                end
            end
        end

        rd_mux = '0;
        if (addr == ADDR_W'(OFS_CTL))
            rd_mux = DATA_W'({st_q.ctl.clr, 2'b00, st_q.ctl.start, st_q.ctl.en});
        for (int i = 0; i < NUM_CNT; i++) begin
            if (addr == ADDR_W'(int'(OFS_CFG0) + 4 * i))
                rd_mux = DATA_W'(st_q.cfg[i]);
        end
        if (addr == ADDR_W'(OFS_SEL)) rd_mux = DATA_W'(st_q.sel);
        if (addr == ADDR_W'(OFS_LO))  rd_mux = st_q.snap[DATA_W-1:0];
        if (addr == ADDR_W'(OFS_HI))  rd_mux = DATA_W'(st_q.snap >> DATA_W);

        if (rd_en) st_d.rdata = rd_mux;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata = st_q.rdata;
    assign ctl   = st_q.ctl;
    assign cfg   = st_q.cfg;
    assign snap  = st_q.snap;

endmodule

// File: rtl/lnk_pmu_bank.sv
module lnk_pmu_bank
    import lnk_pmu_pkg::*;
#(
    parameter int NUM_CNT = 8,
    parameter int CNT_W   = 64,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [EVT_N-1:0]  evt_in
);

    glb_ctl_t                       ctl;
    cnt_cfg_t [NUM_CNT-1:0]         cfg;
    logic [NUM_CNT-1:0]             hit;
    logic [NUM_CNT-1:0][CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]               snap;
    logic                           run;
    logic                           clr;

    assign run = ctl.en & ctl.start & ~ctl.clr;
    assign clr = ctl.clr;

    lnk_pmu_regs #(
        .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .cnt(cnt), .rdata(rdata),
        .ctl(ctl), .cfg(cfg), .snap(snap)
    );

    lnk_pmu_trig #(
        .NUM_CNT(NUM_CNT)
    ) u_trig (
        .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .cfg(cfg), .hit(hit)
    );

    lnk_pmu_ctr #(
        .NUM_CNT(NUM_CNT), .CNT_W(CNT_W)
    ) u_ctr (
        .clk(clk), .rst_n(rst_n), .run(run), .clr(clr), .hit(hit), .cnt(cnt)
    );

endmodule

// File: rtl/lnk_pmu_chk.sv
module lnk_pmu_chk
    import lnk_pmu_pkg::*;
#(
    parameter int NUM_CNT = 8,
    parameter int CNT_W   = 64,
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic                            rd_en,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [DATA_W-1:0]               wdata,
    input  logic [DATA_W-1:0]               rdata,
    input  logic                            c_en,
    input  logic                            c_start,
    input  logic                            c_clr,
    input  logic [NUM_CNT-1:0][CNT_W-1:0]   cnt,
    input  logic [CNT_W-1:0]                snap
);

    function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
        logic m;
        m = (a == ADDR_W'(OFS_CTL)) || (a == ADDR_W'(OFS_SEL)) ||
            (a == ADDR_W'(OFS_LO))  || (a == ADDR_W'(OFS_HI));
        for (int i = 0; i < NUM_CNT; i++)
            if (a == ADDR_W'(int'(OFS_CFG0) + 4 * i)) m = 1'b1;
        return m;
    endfunction

    logic sel_oor;
    assign sel_oor = (wdata < DATA_W'(SEL_BASE)) || (wdata >= DATA_W'(SEL_BASE + NUM_CNT));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(c_en && c_start) && !c_clr) |=> $stable(cnt));

    // R3
    clear_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        c_clr |=> (cnt == '0));

    // R3
    clr_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (c_clr && !(wr_en && addr == ADDR_W'(OFS_CTL))) |=> !c_clr);

    // R8
    sel_oor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_W'(OFS_SEL) && sel_oor) |=> (snap == '0));

    // R9
    snap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == ADDR_W'(OFS_SEL)) |=> $stable(snap));

    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !is_mapped(addr)) |=> (rdata == '0));

    // R10
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));

    for (genvar g = 0; g < NUM_CNT; g++) begin : g_step
        // R8
        snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == ADDR_W'(OFS_SEL) && wdata == DATA_W'(SEL_BASE + g))
            |=> (snap == $past(cnt[g])));

        // R6
        unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !c_clr |=> ((cnt[g] == $past(cnt[g])) || (cnt[g] == $past(cnt[g]) + CNT_W'(1))));
    end

endmodule

bind lnk_pmu_bank lnk_pmu_chk #(
    .NUM_CNT(NUM_CNT), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .c_en(ctl.en), .c_start(ctl.start),
    .c_clr(ctl.clr), .cnt(cnt), .snap(snap)
);

// File: tb/lnk_pmu_bank_test.sv
module lnk_pmu_bank_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  evt_in = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    lnk_pmu_bank uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .evt_in(evt_in)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a; rd_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic step(input logic [3:0] v);
        evt_in = v;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic read_cnt(input int n, output logic [63:0] v);
        logic [31:0] lo, hi;
        wr(12'h12C, 32'(8 + n));
        rd(12'h130, lo);
        rd(12'h134, hi);
        v = {hi, lo};
    endtask

    task automatic t_reset_state;
        logic [31:0] d;
        rd(12'h108, d); chk("R1 ctl", 64'(d), 0);
        rd(12'h10C, d); chk("R1 cfg0", 64'(d), 0);
        rd(12'h128, d); chk("R1 cfg7", 64'(d), 0);
        rd(12'h12C, d); chk("R1 sel", 64'(d), 0);
        rd(12'h130, d); chk("R1 lo", 64'(d), 0);
        rd(12'h134, d); chk("R1 hi", 64'(d), 0);
    endtask

    task automatic t_config;
        logic [31:0] d;
        wr(12'h10C, 32'hABCD_0C3D);
        wr(12'h110, 32'h0000_043D);
        wr(12'h114, 32'h0000_003D);
        wr(12'h118, 32'h0000_083D);
        wr(12'h11C, 32'h0000_0465);
        wr(12'h120, 32'h0000_003E);
        wr(12'h124, 32'h0000_0505);
        wr(12'h128, 32'h0000_0D2D);
        rd(12'h10C, d); chk("R4 cfg0 masked", 64'(d), 64'hC3D);
        rd(12'h128, d); chk("R4 cfg7", 64'(d), 64'hD2D);
    endtask

    task automatic t_gating;
        logic [63:0] v;
        evt_in = 4'hF;
        for (int i = 0; i < 4; i++) step(4'hF);
        wr(12'h108, 32'h1);
        for (int i = 0; i < 4; i++) step(4'hF);
        wr(12'h108, 32'h2);
        for (int i = 0; i < 4; i++) step(4'h0);
        wr(12'h108, 32'h0);
        read_cnt(1, v); chk("R2 level-high gated", v, 0);
        read_cnt(2, v); chk("R2 level-low gated", v, 0);
    endtask

    task automatic t_modes;
        logic [63:0] v;
        logic [63:0] exp [8] = '{64'd4, 64'd12, 64'd9, 64'd4, 64'd0, 64'd0, 64'd7, 64'd10};
        evt_in = 4'h0;
        wr(12'h108, 32'h3);
        for (int i = 0; i < 20; i++)
            step({(i % 2) == 0, i < 7, 1'b0, (i % 5) < 3});
        evt_in = 4'h0;
        wr(12'h108, 32'h0);
        for (int n = 0; n < 8; n++) begin
            read_cnt(n, v);
            case (n)
                0: chk("R6 rising edge", v, exp[n]);
                1: chk("R7 level high", v, exp[n]);
                2: chk("R7 level low", v, exp[n]);
                3: chk("R6 falling edge", v, exp[n]);
                4: chk("R5 snoop idle", v, exp[n]);
                5: chk("R5 unmapped code", v, exp[n]);
                6: chk("R5 data level", v, exp[n]);
                default: chk("R5 irq edge", v, exp[n]);
            endcase
        end
    endtask

    task automatic t_hold;
        logic [31:0] d;
        logic [63:0] v;
        wr(12'h12C, 32'd9);
        wr(12'h108, 32'h3);
        for (int i = 0; i < 4; i++) step(4'h1);
        rd(12'h130, d); chk("R9 snapshot held", 64'(d), 64'd12);
        step(4'h0);
        wr(12'h108, 32'h0);
        read_cnt(1, v); chk("R9 reselect level high", v, 64'd17);
        read_cnt(2, v); chk("R9 reselect level low", v, 64'd11);
        read_cnt(3, v); chk("R6 falling after resume", v, 64'd5);
    endtask

    task automatic t_select;
        logic [31:0] d;
        wr(12'h12C, 32'd3);
        rd(12'h130, d); chk("R8 out-of-range low", 64'(d), 0);
        rd(12'h134, d); chk("R8 out-of-range high", 64'(d), 0);
        rd(12'h12C, d); chk("R8 sel readback", 64'(d), 3);
        wr(12'h12C, 32'd16);
        rd(12'h130, d); chk("R8 sel 16 low", 64'(d), 0);
    endtask

    task automatic t_clear;
        logic [31:0] d;
        logic [63:0] v;
        wr(12'h108, 32'h10);
        rd(12'h108, d); chk("R3 clr bit visible", 64'(d), 64'h10);
        rd(12'h108, d); chk("R3 clr bit self-clears", 64'(d), 0);
        read_cnt(1, v); chk("R3 counter1 cleared", v, 0);
        read_cnt(7, v); chk("R3 counter7 cleared", v, 0);
    endtask

    task automatic t_unmapped;
        logic [31:0] d;
        rd(12'h100, d); chk("R10 below map", 64'(d), 0);
        rd(12'h138, d); chk("R10 above map", 64'(d), 0);
        rd(12'h10E, d); chk("R10 misaligned", 64'(d), 0);
        rd(12'h128, d); chk("R10 mapped after zero", 64'(d), 64'hD2D);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_config();
        t_gating();
        t_modes();
        t_hold();
        t_select();
        t_clear();
        t_unmapped();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule